// File: doc/BRIEF.md
# SDRAM Bank Open/Idle Tracker

This block sits beside the command scheduler of an SDRAM controller and follows the command stream that the controller sends to the memory. It keeps a small state machine and three down-counters for each of the four banks. From these it tracks whether a bank is idle, holds an open row, is waiting for an automatic close, or is recovering from a precharge. The outputs are per-bank flags that tell the scheduler which commands each bank can take in the next cycle. The scheduler is expected to issue a command only where the matching flag is high.

All timing values are clock-cycle counts fixed at elaboration. These are the minimum row-active time, the precharge recovery time, the burst length, the CAS latency and the write recovery. A read or write may ask for an automatic close. The bank then closes by itself at the later of two points: when its row-active minimum is met, or when the burst-derived delay has run out. A precharge-all closes every bank at once. The block observes commands and never stalls them, so there is no back-pressure at its edge. A command sent against a low flag is dropped and latched into a sticky error flag. An all-idle flag is provided for a refresh engine.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While reset is active and in the cycle after it, every bank is idle: `act_rdy`=4'hF, `rw_rdy`=0, `pre_rdy`=4'hF, `all_idle`=1, `cmd_err`=0.
- R2: The command code on `cmd_op` is 0 no-op, 1 activate, 2 read, 3 write, 4 precharge. The bank is selected by `cmd_bank[1:0]` (bit i of every flag vector belongs to bank i). An activate accepted at edge n sets `rw_ready` for that bank from edge n on. A read or write with `cmd_ap`=0 leaves the bank open.
- R3: A precharge with `cmd_ap`=0 to an open bank is accepted only from the T_RAS-th edge after its activate onwards. The bank then shows `act_rdy` again T_RP edges after the precharge.
- R4: A read or write with `cmd_ap`=1 closes the bank on its own, with no further command. The close happens at the later of two edges: activate + T_RAS, and command + D. D is BURST_LEN+CAS_LAT for a read and BURST_LEN+WR_REC for a write. `act_rdy` returns T_RP edges after that close.
- R5: From the edge that accepts a read or write with `cmd_ap`=1 until the bank closes, all three of its ready flags are low.
- R6: A precharge with `cmd_ap`=1 is a precharge-all. It is accepted only when no bank is waiting for an automatic close and every open bank has met T_RAS. It puts all four banks into recovery, and `act_rdy` returns for all of them T_RP edges later.
- R7: `all_idle` is high exactly when all four `act_rdy` bits are high, and then no bank is open.
- R8: A command whose needed flag is low has no effect on any bank and sets `cmd_err` at that edge. `cmd_err` stays set until reset.
- R9: Codes 5 to 7 on `cmd_op` are treated as no-ops: they change no bank and do not set `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_op | input | 3 | Command code issued this cycle |
| cmd_bank | input | 2 | Target bank of the command |
| cmd_ap | input | 1 | Address bit 10: auto-close on read/write, all-banks on precharge |
| act_rdy | output | 4 | Bank may take an activate |
| rw_rdy | output | 4 | Bank may take a read or write |
| pre_rdy | output | 4 | Bank may take a precharge |
| all_idle | output | 1 | All banks idle, for a refresh engine |
| cmd_err | output | 1 | Sticky: a command was issued against a low ready flag |

## Verification
The bench builds the block with T_RAS=7, T_RP=3, BURST_LEN=2, CAS_LAT=2 and WR_REC=1. This gives an auto-close delay of 4 cycles for reads and 3 for writes, both shorter than the row-active minimum. An auto-close issued right after an activate is therefore timed by T_RAS. The same command issued long after the activate is timed by the burst delay, and the one-cycle gap between read and write shows up there. The three-cycle recovery is long enough to see precharge-all hold every bank, including those that were already idle.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_OPEN   = 2'd1,
    BK_APWAIT = 2'd2,
    BK_RECOV  = 2'd3
  } bank_st_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int T_RAS  = 5,
  parameter int T_RP   = 2,
  parameter int RD_DLY = 6,
  parameter int WR_DLY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic rw_i,
  input  logic wr_i,
  input  logic ap_i,
  input  logic pre_i,
  input  logic pall_i,
  output logic act_ok_o,
  output logic rw_ok_o,
  output logic pre_ok_o
);

  localparam int MAXV = max4(T_RAS, T_RP, RD_DLY, WR_DLY);
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] RAS_LD = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);
  localparam logic [CW-1:0] RD_LD  = CW'(RD_DLY - 1);
  localparam logic [CW-1:0] WR_LD  = CW'(WR_DLY - 1);
  localparam logic [CW-1:0] ONE    = CW'(1);

  bank_st_e        st_q, st_d;
  logic [CW-1:0]   ras_q, ras_d;
  logic [CW-1:0]   apc_q, apc_d;
  logic [CW-1:0]   rp_q,  rp_d;
  logic            ras_met, ap_done, rp_done;

  assign ras_met = (ras_q == '0);
  assign ap_done = (apc_q == '0);
  assign rp_done = (rp_q == '0);

  always_comb begin
    st_d  = st_q;
    ras_d = ras_met ? '0 : ras_q - ONE;
    apc_d = ap_done ? '0 : apc_q - ONE;
    rp_d  = rp_done ? '0 : rp_q - ONE;
    if (act_i) begin
      st_d  = BK_OPEN;
      ras_d = RAS_LD;
    end else if (rw_i && ap_i) begin
      st_d  = BK_APWAIT;
      apc_d = wr_i ? WR_LD : RD_LD;
    end else if (pall_i || (pre_i && st_q == BK_OPEN)) begin
      st_d = BK_RECOV;
      rp_d = RP_LD;
    end else if (st_q == BK_APWAIT && ap_done && ras_met) begin
      st_d = BK_RECOV;
      rp_d = RP_LD;
    end else if (st_q == BK_RECOV && rp_done) begin
      st_d = BK_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      ras_q <= '0;
      apc_q <= '0;
      rp_q  <= '0;
    end else begin
      st_q  <= st_d;
      ras_q <= ras_d;
      apc_q <= apc_d;
      rp_q  <= rp_d;
    end
  end

  assign act_ok_o = (st_q == BK_IDLE) || (st_q == BK_RECOV && rp_done);
  assign rw_ok_o  = (st_q == BK_OPEN);
  assign pre_ok_o = (st_q != BK_APWAIT) && !(st_q == BK_OPEN && !ras_met);

endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic                 cmd_ap,
  input  logic [NUM_BANKS-1:0] act_ok,
  input  logic [NUM_BANKS-1:0] rw_ok,
  input  logic [NUM_BANKS-1:0] pre_ok,
  output logic [NUM_BANKS-1:0] act_v,
  output logic [NUM_BANKS-1:0] rw_v,
  output logic [NUM_BANKS-1:0] pre_v,
  output logic                 pall_v,
  output logic                 wr_flag,
  output logic                 illegal
);

  logic [NUM_BANKS-1:0] sel;
  logic is_act, is_rw, is_pre, is_pall;
  logic ok_act, ok_rw, ok_pre, ok_pall;

  assign is_act  = (cmd_op == OP_ACT);
  assign is_rw   = (cmd_op == OP_RD) || (cmd_op == OP_WR);
  assign is_pre  = (cmd_op == OP_PRE) && !cmd_ap;
  assign is_pall = (cmd_op == OP_PRE) && cmd_ap;
  assign wr_flag = (cmd_op == OP_WR);

  assign ok_act  = act_ok[cmd_bank];
  assign ok_rw   = rw_ok[cmd_bank];
  assign ok_pre  = pre_ok[cmd_bank];
  assign ok_pall = &pre_ok;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign sel[i]   = (cmd_bank == BANK_W'(i));
    assign act_v[i] = sel[i] && is_act && ok_act;
    assign rw_v[i]  = sel[i] && is_rw && ok_rw;
    assign pre_v[i] = sel[i] && is_pre && ok_pre;
  end

  assign pall_v  = is_pall && ok_pall;
  assign illegal = (is_act && !ok_act) || (is_rw && !ok_rw) ||
                   (is_pre && !ok_pre) || (is_pall && !ok_pall);

endmodule

// File: rtl/sdram_trk_status.sv
module sdram_trk_status
  import sdram_trk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 illegal,
  input  logic [NUM_BANKS-1:0] act_ok,
  output logic                 all_idle,
  output logic                 err
);

  logic err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | illegal;
  end

  assign err      = err_q;
  assign all_idle = &act_ok;

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int T_RAS     = 5,
  parameter int T_RP      = 2,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int WR_REC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd_op,
  input  logic [1:0] cmd_bank,
  input  logic       cmd_ap,
  output logic [3:0] act_rdy,
  output logic [3:0] rw_rdy,
  output logic [3:0] pre_rdy,
  output logic       all_idle,
  output logic       cmd_err
);

  localparam int RD_DLY = BURST_LEN + CAS_LAT;
  localparam int WR_DLY = BURST_LEN + WR_REC;

  logic [NUM_BANKS-1:0] act_ok, rw_ok, pre_ok;
  logic [NUM_BANKS-1:0] act_v, rw_v, pre_v;
  logic                 pall_v, wr_flag, illegal;

  sdram_cmd_decode u_dec (
    .cmd_op   (cmd_op),
    .cmd_bank (cmd_bank),
    .cmd_ap   (cmd_ap),
    .act_ok   (act_ok),
    .rw_ok    (rw_ok),
    .pre_ok   (pre_ok),
    .act_v    (act_v),
    .rw_v     (rw_v),
    .pre_v    (pre_v),
    .pall_v   (pall_v),
    .wr_flag  (wr_flag),
    .illegal  (illegal)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_bank_fsm #(
      .T_RAS  (T_RAS),
      .T_RP   (T_RP),
      .RD_DLY (RD_DLY),
      .WR_DLY (WR_DLY)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (act_v[b]),
      .rw_i     (rw_v[b]),
      .wr_i     (wr_flag),
      .ap_i     (cmd_ap),
      .pre_i    (pre_v[b]),
      .pall_i   (pall_v),
      .act_ok_o (act_ok[b]),
      .rw_ok_o  (rw_ok[b]),
      .pre_ok_o (pre_ok[b])
    );
  end

  sdram_trk_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .illegal  (illegal),
    .act_ok   (act_ok),
    .all_idle (all_idle),
    .err      (cmd_err)
  );

  assign act_rdy = act_ok;
  assign rw_rdy  = rw_ok;
  assign pre_rdy = pre_ok;

endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmd_op,
  input logic [1:0] cmd_bank,
  input logic       cmd_ap,
  input logic [3:0] act_rdy,
  input logic [3:0] rw_rdy,
  input logic [3:0] pre_rdy,
  input logic       all_idle,
  input logic       cmd_err
);

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && act_rdy[cmd_bank]) |=> rw_rdy[$past(cmd_bank)]);

  assert_early_pre_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd4 && !cmd_ap && !pre_rdy[cmd_bank]) |=> cmd_err);

  assert_ap_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_op == 3'd2 || cmd_op == 3'd3) && cmd_ap && rw_rdy[cmd_bank])
      |=> (!rw_rdy[$past(cmd_bank)] && !pre_rdy[$past(cmd_bank)]));

  assert_pall_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd4 && cmd_ap && (&pre_rdy)) |=> (rw_rdy == 4'b0000));

  assert_idle_none_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    all_idle |-> (rw_rdy == 4'b0000));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  assert_bad_act_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && !act_rdy[cmd_bank]) |=> cmd_err);

endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk u_chk (.*);

// File: tb/sdram_bank_tracker_test.sv
`timescale 1ns/1ps
module sdram_bank_tracker_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_ap = 1'b0;
  logic [3:0] act_rdy, rw_rdy, pre_rdy;
  logic       all_idle, cmd_err;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_bank_tracker #(
    .T_RAS(7), .T_RP(3), .BURST_LEN(2), .CAS_LAT(2), .WR_REC(1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_ap(cmd_ap), .act_rdy(act_rdy), .rw_rdy(rw_rdy), .pre_rdy(pre_rdy),
    .all_idle(all_idle), .cmd_err(cmd_err)
  );

  // fields: op[18:16] bank[15:14] ap[13] act[12:9] rw[8:5] pre[4:1] idle[0]
  localparam logic [18:0] VEC [0:23] = '{
    {3'd0, 2'd0, 1'b0, 4'hF, 4'h0, 4'hF, 1'b1}, // idle
    {3'd1, 2'd0, 1'b0, 4'hE, 4'h1, 4'hE, 1'b0}, // R2 open b0
    {3'd1, 2'd1, 1'b0, 4'hC, 4'h3, 4'hC, 1'b0}, // R2 open b1
    {3'd2, 2'd0, 1'b1, 4'hC, 4'h2, 4'hC, 1'b0}, // R5 read+ap b0
    {3'd3, 2'd1, 1'b0, 4'hC, 4'h2, 4'hC, 1'b0}, // R2 write, stays open
    {3'd0, 2'd0, 1'b0, 4'hC, 4'h2, 4'hC, 1'b0},
    {3'd0, 2'd0, 1'b0, 4'hC, 4'h2, 4'hC, 1'b0},
    {3'd0, 2'd0, 1'b0, 4'hC, 4'h2, 4'hC, 1'b0}, // R4 waits on T_RAS
    {3'd0, 2'd0, 1'b0, 4'hC, 4'h2, 4'hF, 1'b0}, // R4 b0 closes, R3 b1 met
    {3'd4, 2'd1, 1'b0, 4'hC, 4'h0, 4'hF, 1'b0}, // R3 precharge b1
    {3'd0, 2'd0, 1'b0, 4'hD, 4'h0, 4'hF, 1'b0}, // R4 b0 back
    {3'd0, 2'd0, 1'b0, 4'hF, 4'h0, 4'hF, 1'b1}, // R3 b1 back, R7
    {3'd1, 2'd2, 1'b0, 4'hB, 4'h4, 4'hB, 1'b0},
    {3'd1, 2'd3, 1'b0, 4'h3, 4'hC, 4'h3, 1'b0},
    {3'd3, 2'd3, 1'b1, 4'h3, 4'h4, 4'h3, 1'b0}, // R5 write+ap b3
    {3'd0, 2'd0, 1'b0, 4'h3, 4'h4, 4'h3, 1'b0},
    {3'd0, 2'd0, 1'b0, 4'h3, 4'h4, 4'h3, 1'b0},
    {3'd0, 2'd0, 1'b0, 4'h3, 4'h4, 4'h3, 1'b0},
    {3'd0, 2'd0, 1'b0, 4'h3, 4'h4, 4'h7, 1'b0}, // R3 b2 met
    {3'd0, 2'd0, 1'b0, 4'h3, 4'h4, 4'h7, 1'b0},
    {3'd0, 2'd0, 1'b0, 4'h3, 4'h4, 4'hF, 1'b0}, // R4 b3 closes at T_RAS
    {3'd4, 2'd0, 1'b1, 4'h0, 4'h0, 4'hF, 1'b0}, // R6 precharge-all
    {3'd0, 2'd0, 1'b0, 4'h0, 4'h0, 4'hF, 1'b0},
    {3'd0, 2'd0, 1'b0, 4'hF, 4'h0, 4'hF, 1'b1}  // R6 all back, R7
  };

  function automatic logic [13:0] mk(input logic [3:0] a, input logic [3:0] r,
                                     input logic [3:0] p, input logic i,
                                     input logic e);
    return {a, r, p, i, e};
  endfunction

  task automatic step(input logic [2:0] op, input logic [1:0] b, input logic ap);
    @(negedge clk);
    cmd_op = op; cmd_bank = b; cmd_ap = ap;
    @(posedge clk);
    #1;
  endtask

  task automatic nops(input int k);
    for (int j = 0; j < k; j++) step(3'd0, 2'd0, 1'b0);
  endtask

  task automatic check(input string req, input logic [13:0] exp);
    logic [13:0] got;
    got = {act_rdy, rw_rdy, pre_rdy, all_idle, cmd_err};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: act/rw/pre/idle/err got %h_%h_%h_%b_%b expected %h_%h_%h_%b_%b",
               req, got[13:10], got[9:6], got[5:2], got[1], got[0],
               exp[13:10], exp[9:6], exp[5:2], exp[1], exp[0]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_op = 3'd0; cmd_bank = 2'd0; cmd_ap = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    #1;
    check("R1 reset state", mk(4'hF, 4'h0, 4'hF, 1'b1, 1'b0));

    for (int i = 0; i < 24; i++) begin
      step(VEC[i][18:16], VEC[i][15:14], VEC[i][13]);
      check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i), {VEC[i][12:0], 1'b0});
    end

    // R1: reset in the middle of activity
    step(3'd1, 2'd2, 1'b0);
    @(negedge clk); rst_n = 1'b0; cmd_op = 3'd0;
    @(posedge clk); #1;
    check("R1 reset while open", mk(4'hF, 4'h0, 4'hF, 1'b1, 1'b0));
    @(negedge clk); rst_n = 1'b1;

    // R9 reserved code, then R8 read to idle bank
    step(3'd7, 2'd1, 1'b1);
    check("R9 reserved op ignored", mk(4'hF, 4'h0, 4'hF, 1'b1, 1'b0));
    step(3'd2, 2'd1, 1'b0);
    check("R8 read to idle bank", mk(4'hF, 4'h0, 4'hF, 1'b1, 1'b1));

    // R3/R8: early precharge dropped
    do_reset();
    step(3'd1, 2'd0, 1'b0);
    check("R2 open b0", mk(4'hE, 4'h1, 4'hE, 1'b0, 1'b0));
    step(3'd4, 2'd0, 1'b0);
    check("R3 early precharge ignored", mk(4'hE, 4'h1, 4'hE, 1'b0, 1'b1));

    // R4: read auto-close timed by burst delay (4) + recovery (3)
    do_reset();
    step(3'd1, 2'd0, 1'b0);
    nops(7);
    step(3'd2, 2'd0, 1'b1);
    check("R5 read+ap blocks b0", mk(4'hE, 4'h0, 4'hE, 1'b0, 1'b0));
    nops(5);
    check("R4 read close not yet", mk(4'hE, 4'h0, 4'hF, 1'b0, 1'b0));
    nops(1);
    check("R4 read close done", mk(4'hF, 4'h0, 4'hF, 1'b1, 1'b0));

    // R4: write auto-close one cycle sooner
    do_reset();
    step(3'd1, 2'd0, 1'b0);
    nops(7);
    step(3'd3, 2'd0, 1'b1);
    nops(4);
    check("R4 write close not yet", mk(4'hE, 4'h0, 4'hF, 1'b0, 1'b0));
    nops(1);
    check("R4 write close done", mk(4'hF, 4'h0, 4'hF, 1'b1, 1'b0));

    // R5/R6/R8: commands against a pending auto-close
    do_reset();
    step(3'd1, 2'd0, 1'b0);
    step(3'd1, 2'd1, 1'b0);
    step(3'd2, 2'd0, 1'b1);
    check("R5 pending b0", mk(4'hC, 4'h2, 4'hC, 1'b0, 1'b0));
    step(3'd1, 2'd0, 1'b0);
    check("R5 activate to pending bank", mk(4'hC, 4'h2, 4'hC, 1'b0, 1'b1));
    step(3'd4, 2'd0, 1'b1);
    check("R6 precharge-all held off", mk(4'hC, 4'h2, 4'hC, 1'b0, 1'b1));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule